// File: doc/BRIEF.md
# Audio Link Receive Status Register

This block is the receive-side status word of a serial audio codec link. The frame deserializer sends it one-cycle strobes when new data arrives in slots 1 to 4. The block turns these strobes into sticky flags:

- status address received (slot 1);
- status data received (slot 2);
- left PCM sample pending (slot 3);
- right PCM sample pending (slot 4);
- overrun, one flag for each PCM channel.

Software reads the word through a plain register port. It clears flags by writing zeros to them.

When DMA mode is selected, a read of a PCM data register retires the pending request of that channel. The DMA engine can then drain samples without any software writes. An overrun flag records that a PCM sample arrived while the previous sample of that channel was still unread.

Top module: `aud_rx_status`

## Requirements
- R1: After reset every bit of `regRdData` is 0.
- R2: A strobe on `slotArrive[0]`, `[1]`, `[2]` or `[3]` sets read bit 22, 21, 20 or 19 respectively. The bit is visible on the cycle after the strobe.
- R3: A write (`regWrEn`=1) with a 0 in bit 22, 21, 20, 19, 13 or 12 clears that flag. A 1 in the same position leaves the flag unchanged.
- R4: Bits 31..23, 18..14 and 11..0 always read 0, whatever value is written.
- R5: If a flag's set event and a write-0 clear of that flag fall in the same cycle, the flag ends up 1.
- R6: With `dmaMode`=1, `pcmRd[0]` (left) clears bit 20 and `pcmRd[1]` (right) clears bit 19 on the next cycle, unless a new arrival for that channel occurs in the same cycle.
- R7: With `dmaMode`=0, `pcmRd` has no effect on any flag.
- R8: Bit 13 sets when `slotArrive[2]` occurs while bit 20 is already 1, unless a DMA read of the left channel happens in the same cycle. Bit 12 behaves the same way for `slotArrive[3]`, bit 19 and the right channel.
- R9: An overrun flag stays set until software writes 0 to it, even after its request flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slotArrive | input | 4 | New-data strobes; bit k is for slot k+1 |
| dmaMode | input | 1 | 1 = DMA mode; PCM data reads retire requests |
| pcmRd | input | 2 | Read strobes of the PCM data registers; bit 0 left, bit 1 right |
| regWrEn | input | 1 | Write strobe of the status register |
| regWrData | input | REG_W | Write data; 0 in a flag position clears that flag |
| regRdData | output | REG_W | Current status word |

## Verification
The bench builds the block with its default 32-bit word. At that width every flag position and every reserved gap exists, so all of them can be checked at the ports.

The directed scenarios cover:
- collisions of a set event with a clear in the same cycle, both from software writes and from DMA reads;
- back-to-back arrivals that produce an overrun, on each channel separately;
- PCM reads outside DMA mode, where they must leave the word unchanged.

// File: rtl/aud_rx_status_pkg.sv
package aud_rx_status_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int NUM_PCM   = 2;
  // flag index order: 0 stsAddr, 1 stsData, 2 leftReq, 3 rightReq, 4 leftOvr, 5 rightOvr
  localparam int REQ_BASE  = 2;
  localparam int OVR_BASE  = 4;
  localparam int FLAG_POS [NUM_FLAGS] = '{22, 21, 20, 19, 13, 12};
  localparam int MIN_W     = 23;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setFlag;
    logic [NUM_FLAGS-1:0] clrFlag;
  } flagCtl_t;
endpackage

// File: rtl/aud_rx_status_ctrl.sv
module aud_rx_status_ctrl
  import aud_rx_status_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           slotArrive,
  input  logic                 dmaMode,
  input  logic [NUM_PCM-1:0]   pcmRd,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [NUM_FLAGS-1:0] flagQ,
  output flagCtl_t             ctl
);
  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] wrClr;
  logic [NUM_FLAGS-1:0] clrVec;
  logic [NUM_PCM-1:0]   dmaTake;

  assign setVec[0] = slotArrive[0];
  assign setVec[1] = slotArrive[1];

  genvar c;
  generate
    for (c = 0; c < NUM_PCM; c++) begin : g_pcm
      assign dmaTake[c]           = dmaMode & pcmRd[c];
      assign setVec[REQ_BASE + c] = slotArrive[REQ_BASE + c];
      // overrun: new sample while previous still pending and not being taken now
      assign setVec[OVR_BASE + c] = slotArrive[REQ_BASE + c] & flagQ[REQ_BASE + c] & ~dmaTake[c];
      assign clrVec[REQ_BASE + c] = wrClr[REQ_BASE + c] | dmaTake[c];
      assign clrVec[OVR_BASE + c] = wrClr[OVR_BASE + c];

      assert_no_dma_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dmaMode && !regWrEn) |-> !clrVec[REQ_BASE + c]);
    end
  endgenerate

  assign clrVec[0] = wrClr[0];
  assign clrVec[1] = wrClr[1];

  genvar i;
  generate
    for (i = 0; i < NUM_FLAGS; i++) begin : g_wr
      assign wrClr[i] = regWrEn & ~regWrData[FLAG_POS[i]];
    end
  endgenerate

  assign ctl.setFlag = setVec;
  assign ctl.clrFlag = clrVec;
endmodule

// File: rtl/aud_rx_status_dp.sv
module aud_rx_status_dp
  import aud_rx_status_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  flagCtl_t             ctl,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [REG_W-1:0]     regRdData
);
  always_ff @(posedge clk) begin
    if (!rst_n) flagQ <= '0;
    else        flagQ <= ctl.setFlag | (flagQ & ~ctl.clrFlag);
  end

  always_comb begin
    regRdData = '0;
    for (int k = 0; k < NUM_FLAGS; k++) regRdData[FLAG_POS[k]] = flagQ[k];
  end

  genvar i;
  generate
    for (i = 0; i < NUM_FLAGS; i++) begin : g_chk
      assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.setFlag[i] && ctl.clrFlag[i]) |=> flagQ[i]);
      assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.setFlag[i] && !ctl.clrFlag[i]) |=> $stable(flagQ[i]));
    end
  endgenerate
endmodule

// File: rtl/aud_rx_status.sv
module aud_rx_status
  import aud_rx_status_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         slotArrive,
  input  logic               dmaMode,
  input  logic [1:0]         pcmRd,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData
);
  localparam int MASK_W = REG_W;

  flagCtl_t             ctl;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [MASK_W-1:0]    defMask;

  initial begin
    if (REG_W < MIN_W) $error("REG_W too small for flag positions");
  end

  always_comb begin
    defMask = '0;
    for (int k = 0; k < NUM_FLAGS; k++) defMask[FLAG_POS[k]] = 1'b1;
  end

  aud_rx_status_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slotArrive(slotArrive), .dmaMode(dmaMode),
    .pcmRd(pcmRd), .regWrEn(regWrEn), .regWrData(regWrData),
    .flagQ(flagQ), .ctl(ctl)
  );

  aud_rx_status_dp #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .flagQ(flagQ), .regRdData(regRdData)
  );

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData & ~defMask) == '0);
  assert_slot1_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slotArrive[0] |=> regRdData[22]);
  assert_slot4_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slotArrive[3] |=> regRdData[19]);
  assert_dma_left_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaMode && pcmRd[0] && !slotArrive[2]) |=> !regRdData[20]);
  assert_left_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slotArrive[2] && regRdData[20] && !(dmaMode && pcmRd[0])) |=> regRdData[13]);
  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[13] && !(regWrEn && !regWrData[13])) |=> regRdData[13]);
  assert_write_one_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regWrData[21] && regRdData[21]) |=> regRdData[21]);
endmodule

// File: tb/tb_aud_rx_status.sv
`timescale 1ns/1ps
module tb_aud_rx_status;
  localparam int W = 32;
  localparam logic [W-1:0] B_SA = 32'h0040_0000, B_SD = 32'h0020_0000,
                           B_LQ = 32'h0010_0000, B_RQ = 32'h0008_0000,
                           B_LO = 32'h0000_2000, B_RO = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] slotArrive = '0;
  logic dmaMode = 1'b0;
  logic [1:0] pcmRd = '0;
  logic regWrEn = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aud_rx_status #(.REG_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .slotArrive(slotArrive), .dmaMode(dmaMode),
    .pcmRd(pcmRd), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    nChecks++;
    if (regRdData !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, regRdData, exp);
    end
  endtask

  // apply current inputs for one edge, then return them to idle
  task automatic tick();
    @(posedge clk); #1;
    slotArrive = '0; pcmRd = '0; regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic wr(input logic [W-1:0] d);
    regWrEn = 1'b1; regWrData = d; tick();
  endtask

  task automatic arrive(input logic [3:0] s);
    slotArrive = s; tick();
  endtask

  task automatic t_reset();
    check("R1 reset", '0);
  endtask

  task automatic t_arrivals();
    arrive(4'b0001); check("R2 slot1", B_SA);
    arrive(4'b0010); check("R2 slot2", B_SA | B_SD);
    arrive(4'b0100); check("R2 slot3", B_SA | B_SD | B_LQ);
    arrive(4'b1000); check("R2 slot4", B_SA | B_SD | B_LQ | B_RQ);
  endtask

  task automatic t_write();
    wr('1); check("R3 write ones keeps / R4 reserved", B_SA | B_SD | B_LQ | B_RQ);
    wr(~B_SA); check("R3 clear one bit", B_SD | B_LQ | B_RQ);
    wr('0); check("R3 clear all", '0);
  endtask

  task automatic t_overrun();
    arrive(4'b0100); arrive(4'b0100); check("R8 left overrun", B_LQ | B_LO);
    arrive(4'b1000); arrive(4'b1000); check("R8 right overrun", B_LQ | B_LO | B_RQ | B_RO);
    wr(~(B_LQ | B_RQ)); check("R9 overrun sticky", B_LO | B_RO);
    wr(~B_LO); check("R9 write-0 clears overrun", B_RO);
    wr('0); check("R3 clear", '0);
  endtask

  task automatic t_dma();
    dmaMode = 1'b1;
    arrive(4'b1100); check("R2 both requests", B_LQ | B_RQ);
    pcmRd = 2'b01; tick(); check("R6 left dma read", B_RQ);
    pcmRd = 2'b10; tick(); check("R6 right dma read", '0);
    arrive(4'b0100);
    slotArrive = 4'b0100; pcmRd = 2'b01; tick();
    check("R8 no overrun when taken same cycle", B_LQ);
    pcmRd = 2'b01; tick(); check("R6 left clear", '0);
    dmaMode = 1'b0;
  endtask

  task automatic t_nodma();
    arrive(4'b1100);
    pcmRd = 2'b11; tick(); check("R7 reads ignored outside dma", B_LQ | B_RQ);
    wr('0); check("R3 clear", '0);
  endtask

  task automatic t_setwins();
    arrive(4'b0011);
    slotArrive = 4'b0001; regWrEn = 1'b1; regWrData = '0; tick();
    check("R5 set beats clear", B_SA);
    wr('0); check("R3 clear", '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_arrivals();
    t_write();
    t_overrun();
    t_dma();
    t_nodma();
    t_setwins();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule